// File: doc/BRIEF.md
# Load Stride Profiler

This block watches the address stream of one load instruction and builds a small statistical picture of how that address moves. Each new address is subtracted from the one before it to form a stride. Each stride is subtracted from the stride before it to form a stride difference. Non-zero strides are counted in a four-entry frequency table that evicts the least frequently used entry. Strides whose distance from a stored value is under half a cache line count as hits on that value. Zero strides and zero differences are tallied on separate counters.

An end-of-window request freezes a report. The report gives the load's prefetch class, the dominant stride with its count, and the stride, difference, zero-stride and zero-difference totals. Profiling carries on after a report until a clear wipes everything. A prefetch planner reads the class to decide how to prefetch the load: with a fixed distance, with a stride computed at run time, or with a conditional prefetch.

Top module: `stride_prof`

## Requirements
- R1: After reset or `clear`, `reportValid` is 0 and every report output is 0. An end request issued with no addresses reports class 0 and all totals 0.
- R2: The first address after a clear only records the previous address. The second address produces the first stride and no difference. After N addresses (N ≥ 2), the stride total is N-1 and the difference total is N-2.
- R3: The stride is the current address minus the previous address, taken modulo 2^ADDR_W and treated as signed. The reported top stride is the value first stored in the winning entry. Among entries with equal counts, the lowest index wins.
- R4: Zero strides increase the zero-stride total and never enter the table. A stream made only of zero strides reports a top count of 0 and class 0.
- R5: A difference counts as zero only when two successive strides are exactly equal. An alternating stream therefore gets no zero differences.
- R6: A non-zero stride whose distance from a stored entry is strictly less than LINE_BYTES/2 increments that entry. If several entries match, the lowest matching index is used. A distance of exactly LINE_BYTES/2 is a miss.
- R7: A miss takes the lowest free entry. When all entries are in use, a miss replaces the entry with the smallest count (lowest index on a tie), and the new entry starts at count 1.
- R8: Class 1 (strong) is reported when the top count × 10 ≥ stride total × 7 and the top count is non-zero.
- R9: Class 2 (phased) is reported when the sum of the table counts × 10 ≥ stride total × 3 and zero differences × 10 ≥ difference total × 3, with both the sum and the difference total non-zero.
- R10: Class 3 (weak) is reported when the top count × 10 ≥ stride total × 2 and zero differences × 10 ≥ difference total, with both the top count and the difference total non-zero.
- R11: The classes are tried in the order strong, phased, weak. Class 0 means none of them holds.
- R12: An end request captures the report values as they stand before any address accepted in the same cycle. It does not disturb profiling. `reportValid` rises on the next cycle and stays at 1 until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Wipe the profile and the report |
| endWindow | input | 1 | Capture a report |
| addrValid | input | 1 | An address from the load is present |
| addr | input | ADDR_W | Load address |
| reportValid | output | 1 | The report outputs hold a captured report |
| loadClass | output | 2 | Class: 0 none, 1 strong, 2 phased, 3 weak |
| topStride | output | ADDR_W | Dominant non-zero stride (two's complement) |
| topCount | output | CNT_W | Hits on the dominant stride |
| strideTotal | output | CNT_W | Strides seen |
| diffTotal | output | CNT_W | Stride differences seen |
| zeroStrideTotal | output | CNT_W | Zero strides seen |
| zeroDiffTotal | output | CNT_W | Zero differences seen |

## Verification
The bench drives each class threshold at its exact boundary. Exactly 70 % must give strong, and 60 % with many zero differences must fall through to phased. A comparison written with the wrong inequality direction, or a priority mix-up, changes the reported class. Two streams with the same stride histogram, one alternating and one phased, must give different classes; an exact-zero-difference test that is too loose would call the alternating stream weak. Tolerance probes sit at 31 and 32 bytes from an entry and at a stride that matches two entries. Filling the table and forcing evictions where two entries tie on count exposes a victim search that breaks ties toward the wrong index, because the surviving entry later becomes the top stride. A report requested in the same cycle as an address must leave that address out.

// File: rtl/stride_prof_pkg.sv
package stride_prof_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_STRONG = 2'd1,
    CLS_PHASED = 2'd2,
    CLS_WEAK   = 2'd3
  } loadClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wipe;
    logic prime;
    logic takeStride;
    logic takeDiff;
    logic snap;
  } profStrobes_t;

endpackage

// File: rtl/stride_prof_ctrl.sv
module stride_prof_ctrl
  import stride_prof_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         addrValid,
  input  logic         endWindow,
  output profStrobes_t strobes,
  output logic         reportValid
);

  logic havePrev;
  logic haveStride;

  always_comb begin
    strobes.wipe       = clear;
    strobes.snap       = endWindow && !clear;
    strobes.prime      = addrValid && !clear && !havePrev;
    strobes.takeStride = addrValid && !clear && havePrev;
    strobes.takeDiff   = addrValid && !clear && havePrev && haveStride;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      havePrev    <= 1'b0;
      haveStride  <= 1'b0;
      reportValid <= 1'b0;
    end else begin
      if (addrValid) havePrev <= 1'b1;
      if (strobes.takeStride) haveStride <= 1'b1;
      if (endWindow) reportValid <= 1'b1;
    end
  end

endmodule

// File: rtl/stride_prof_judge.sv
module stride_prof_judge
  import stride_prof_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SUM_W = 18
) (
  input  logic [CNT_W-1:0] topCnt,
  input  logic [SUM_W-1:0] topSum,
  input  logic [CNT_W-1:0] strideTot,
  input  logic [CNT_W-1:0] diffTot,
  input  logic [CNT_W-1:0] zeroDiff,
  output loadClass_e       verdict
);

  localparam int WW = SUM_W + 4;

  logic [WW-1:0] top10, sum10, zd10, st7, st3, st2, dt3, dtW;
  logic isStrong, isPhased, isWeak;

  // x*10 = x*8 + x*2, x*7 = x*8 - x, x*3 = x*2 + x
  always_comb begin
    top10 = (WW'(topCnt) << 3) + (WW'(topCnt) << 1);
    sum10 = (WW'(topSum) << 3) + (WW'(topSum) << 1);
    zd10  = (WW'(zeroDiff) << 3) + (WW'(zeroDiff) << 1);
    st7   = (WW'(strideTot) << 3) - WW'(strideTot);
    st3   = (WW'(strideTot) << 1) + WW'(strideTot);
    st2   = WW'(strideTot) << 1;
    dt3   = (WW'(diffTot) << 1) + WW'(diffTot);
    dtW   = WW'(diffTot);

    isStrong = (topCnt != '0) && (top10 >= st7);
    isPhased = (topSum != '0) && (diffTot != '0) && (sum10 >= st3) && (zd10 >= dt3);
    isWeak   = (topCnt != '0) && (diffTot != '0) && (top10 >= st2) && (zd10 >= dtW);

    if (isStrong)      verdict = CLS_STRONG;
    else if (isPhased) verdict = CLS_PHASED;
    else if (isWeak)   verdict = CLS_WEAK;
    else               verdict = CLS_NONE;
  end

endmodule

// File: rtl/stride_prof_dp.sv
module stride_prof_dp
  import stride_prof_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4,
  parameter int SUM_W      = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  profStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  loadClass_e        verdict,
  output logic [CNT_W-1:0]  curTopCnt,
  output logic [SUM_W-1:0]  curTopSum,
  output logic [CNT_W-1:0]  curStrideTot,
  output logic [CNT_W-1:0]  curDiffTot,
  output logic [CNT_W-1:0]  curZeroDiff,
  output loadClass_e        repClass,
  output logic [ADDR_W-1:0] repTopStride,
  output logic [CNT_W-1:0]  repTopCnt,
  output logic [CNT_W-1:0]  repStrideTot,
  output logic [CNT_W-1:0]  repDiffTot,
  output logic [CNT_W-1:0]  repZeroStride,
  output logic [CNT_W-1:0]  repZeroDiff
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic signed [ADDR_W:0] HALF_POS = (ADDR_W+1)'(LINE_BYTES / 2);
  localparam logic signed [ADDR_W:0] HALF_NEG = -HALF_POS;

  logic [ADDR_W-1:0] prevAddr;
  logic [ADDR_W-1:0] prevStride;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] tabStride [ENTRIES];
  logic [CNT_W-1:0]  tabCnt    [ENTRIES];
  logic [ENTRIES-1:0] tabValid;
  logic [ENTRIES-1:0] hitVec;
  logic [CNT_W-1:0]  zeroStride;

  logic             hitAny, freeAny;
  logic [IDX_W-1:0] hitIdx, freeIdx, minIdx, victimIdx, topIdx;

  assign stride = addr - prevAddr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    logic signed [ADDR_W:0] gap;
    assign gap = $signed({stride[ADDR_W-1], stride}) -
                 $signed({tabStride[g][ADDR_W-1], tabStride[g]});
    assign hitVec[g] = tabValid[g] && (gap < HALF_POS) && (gap > HALF_NEG);
  end

  // lowest-index searches
  always_comb begin
    hitAny  = 1'b0;
    freeAny = 1'b0;
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i])    begin hitAny  = 1'b1; hitIdx  = IDX_W'(i); end
      if (!tabValid[i]) begin freeAny = 1'b1; freeIdx = IDX_W'(i); end
    end
    minIdx = '0;
    for (int i = 1; i < ENTRIES; i++)
      if (tabCnt[i] < tabCnt[minIdx]) minIdx = IDX_W'(i);
    victimIdx = hitAny ? hitIdx : (freeAny ? freeIdx : minIdx);
  end

  always_comb begin
    topIdx    = '0;
    curTopSum = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      curTopSum = curTopSum + SUM_W'(tabCnt[i]);
      if (tabCnt[i] > tabCnt[topIdx]) topIdx = IDX_W'(i);
    end
    curTopCnt = tabCnt[topIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.wipe) begin
      prevAddr      <= '0;
      prevStride    <= '0;
      tabValid      <= '0;
      curStrideTot  <= '0;
      curDiffTot    <= '0;
      curZeroDiff   <= '0;
      zeroStride    <= '0;
      repClass      <= CLS_NONE;
      repTopStride  <= '0;
      repTopCnt     <= '0;
      repStrideTot  <= '0;
      repDiffTot    <= '0;
      repZeroStride <= '0;
      repZeroDiff   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tabStride[i] <= '0;
        tabCnt[i]    <= '0;
      end
    end else begin
      if (strobes.prime) prevAddr <= addr;
      if (strobes.takeStride) begin
        prevAddr     <= addr;
        prevStride   <= stride;
        curStrideTot <= curStrideTot + CNT_W'(1);
        if (stride == '0) begin
          zeroStride <= zeroStride + CNT_W'(1);
        end else if (hitAny) begin
          tabCnt[victimIdx] <= tabCnt[victimIdx] + CNT_W'(1);
        end else begin
          tabStride[victimIdx] <= stride;
          tabCnt[victimIdx]    <= CNT_W'(1);
          tabValid[victimIdx]  <= 1'b1;
        end
      end
      if (strobes.takeDiff) begin
        curDiffTot <= curDiffTot + CNT_W'(1);
        if (stride == prevStride) curZeroDiff <= curZeroDiff + CNT_W'(1);
      end
      if (strobes.snap) begin
        repClass      <= verdict;
        repTopStride  <= tabStride[topIdx];
        repTopCnt     <= curTopCnt;
        repStrideTot  <= curStrideTot;
        repDiffTot    <= curDiffTot;
        repZeroStride <= zeroStride;
        repZeroDiff   <= curZeroDiff;
      end
    end
  end

endmodule

// File: rtl/stride_prof.sv
module stride_prof
  import stride_prof_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              endWindow,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  output logic              reportValid,
  output logic [1:0]        loadClass,
  output logic [ADDR_W-1:0] topStride,
  output logic [CNT_W-1:0]  topCount,
  output logic [CNT_W-1:0]  strideTotal,
  output logic [CNT_W-1:0]  diffTotal,
  output logic [CNT_W-1:0]  zeroStrideTotal,
  output logic [CNT_W-1:0]  zeroDiffTotal
);

  localparam int SUM_W = CNT_W + ((ENTRIES > 1) ? $clog2(ENTRIES) : 1);

  profStrobes_t     strobes;
  loadClass_e       verdict, repClass;
  logic [CNT_W-1:0] curTopCnt, curStrideTot, curDiffTot, curZeroDiff;
  logic [SUM_W-1:0] curTopSum;

  stride_prof_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .addrValid(addrValid),
    .endWindow(endWindow), .strobes(strobes), .reportValid(reportValid)
  );

  stride_prof_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES),
    .ENTRIES(ENTRIES), .SUM_W(SUM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .verdict(verdict),
    .curTopCnt(curTopCnt), .curTopSum(curTopSum), .curStrideTot(curStrideTot),
    .curDiffTot(curDiffTot), .curZeroDiff(curZeroDiff),
    .repClass(repClass), .repTopStride(topStride), .repTopCnt(topCount),
    .repStrideTot(strideTotal), .repDiffTot(diffTotal),
    .repZeroStride(zeroStrideTotal), .repZeroDiff(zeroDiffTotal)
  );

  stride_prof_judge #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_judge (
    .topCnt(curTopCnt), .topSum(curTopSum), .strideTot(curStrideTot),
    .diffTot(curDiffTot), .zeroDiff(curZeroDiff), .verdict(verdict)
  );

  assign loadClass = repClass;

endmodule

// File: rtl/stride_prof_chk.sv
module stride_prof_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             endWindow,
  input logic             reportValid,
  input logic [1:0]       loadClass,
  input logic [CNT_W-1:0] topCount,
  input logic [CNT_W-1:0] strideTotal,
  input logic [CNT_W-1:0] diffTotal,
  input logic [CNT_W-1:0] zeroStrideTotal,
  input logic [CNT_W-1:0] zeroDiffTotal
);

  logic [CNT_W+3:0] top10, st7;
  assign top10 = ({4'b0, topCount} << 3) + ({4'b0, topCount} << 1);
  assign st7   = ({4'b0, strideTotal} << 3) - {4'b0, strideTotal};

  p_clear_drops_r1: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !reportValid);

  p_end_raises_r12: assert property (@(posedge clk) disable iff (!rstN)
    (endWindow && !clear) |=> reportValid);

  p_report_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && !clear && !endWindow) |=>
      ($stable(loadClass) && $stable(strideTotal) && $stable(topCount)));

  p_diff_lags_r2: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |-> (diffTotal <= strideTotal && zeroDiffTotal <= diffTotal));

  p_top_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |-> ({1'b0, topCount} + {1'b0, zeroStrideTotal} <= {1'b0, strideTotal}));

  p_empty_none_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && topCount == '0) |-> loadClass == 2'd0);

  p_strong_ratio_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && loadClass == 2'd1) |-> (top10 >= st7));

endmodule

bind stride_prof stride_prof_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .endWindow(endWindow),
  .reportValid(reportValid), .loadClass(loadClass), .topCount(topCount),
  .strideTotal(strideTotal), .diffTotal(diffTotal),
  .zeroStrideTotal(zeroStrideTotal), .zeroDiffTotal(zeroDiffTotal)
);

// File: tb/stride_prof_test.sv
module stride_prof_test;

  typedef struct {
    logic [1:0]  cls;
    logic [31:0] top;
    logic [15:0] cnt;
    logic [15:0] st;
    logic [15:0] dt;
    logic [15:0] zs;
    logic [15:0] zd;
    string       tag;
  } expRep_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        endWindow = 1'b0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic        reportValid;
  logic [1:0]  loadClass;
  logic [31:0] topStride;
  logic [15:0] topCount, strideTotal, diffTotal, zeroStrideTotal, zeroDiffTotal;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] cur = '0;
  logic endLatched = 1'b0;
  expRep_t expQ[$];

  always #10 clk = ~clk;

  stride_prof uut (
    .clk(clk), .rstN(rstN), .clear(clear), .endWindow(endWindow),
    .addrValid(addrValid), .addr(addr), .reportValid(reportValid),
    .loadClass(loadClass), .topStride(topStride), .topCount(topCount),
    .strideTotal(strideTotal), .diffTotal(diffTotal),
    .zeroStrideTotal(zeroStrideTotal), .zeroDiffTotal(zeroDiffTotal)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares a report one cycle after the end request was taken
  always @(posedge clk) endLatched <= endWindow && !clear;

  always @(negedge clk) begin
    if (endLatched) begin
      if (expQ.size() == 0) begin
        check("R12", "unexpected report", 32'd1, 32'd0);
      end else begin
        expRep_t e;
        e = expQ.pop_front();
        check(e.tag, "reportValid", {31'd0, reportValid}, 32'd1);
        check(e.tag, "class", {30'd0, loadClass}, {30'd0, e.cls});
        check(e.tag, "topStride", topStride, e.top);
        check(e.tag, "topCount", {16'd0, topCount}, {16'd0, e.cnt});
        check(e.tag, "strideTotal", {16'd0, strideTotal}, {16'd0, e.st});
        check(e.tag, "diffTotal", {16'd0, diffTotal}, {16'd0, e.dt});
        check(e.tag, "zeroStride", {16'd0, zeroStrideTotal}, {16'd0, e.zs});
        check(e.tag, "zeroDiff", {16'd0, zeroDiffTotal}, {16'd0, e.zd});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  task automatic doClear();
    @(negedge clk);
    clear = 1'b1; addrValid = 1'b0; endWindow = 1'b0;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic pushAddr(input logic [31:0] a);
    @(negedge clk);
    addrValid = 1'b1; addr = a; endWindow = 1'b0;
  endtask

  task automatic prime(input logic [31:0] a);
    cur = a;
    pushAddr(a);
  endtask

  task automatic walk(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      cur = cur + 32'(s);
      pushAddr(cur);
    end
  endtask

  task automatic endReport(input expRep_t e);
    @(negedge clk);
    addrValid = 1'b0; endWindow = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    endWindow = 1'b0;
  endtask

  function automatic expRep_t mk(input logic [1:0] c, input logic [31:0] t,
      input int n, input int st, input int dt, input int zs, input int zd,
      input string tag);
    expRep_t e;
    e.cls = c; e.top = t; e.cnt = 16'(n); e.st = 16'(st); e.dt = 16'(dt);
    e.zs = 16'(zs); e.zd = 16'(zd); e.tag = tag;
    return e;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset reportValid", {31'd0, reportValid}, 32'd0);
    check("R1", "reset class", {30'd0, loadClass}, 32'd0);
    check("R1", "reset strideTotal", {16'd0, strideTotal}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty window
    endReport(mk(2'd0, 32'd0, 0, 0, 0, 0, 0, "R1"));
    doClear();
    @(negedge clk);
    check("R1", "clear drops reportValid", {31'd0, reportValid}, 32'd0);

    // R2: a single address yields nothing, a second gives one stride
    prime(32'h1000);
    endReport(mk(2'd0, 32'd0, 0, 0, 0, 0, 0, "R2"));
    walk(40, 1);
    endReport(mk(2'd1, 32'd40, 1, 1, 0, 0, 0, "R2"));

    // R8: exactly 70 percent is strong
    doClear(); prime(32'h2000);
    walk(128, 7); walk(0, 3);
    endReport(mk(2'd1, 32'd128, 7, 10, 9, 3, 8, "R8"));

    // R11 / R9: 60 percent falls to phased
    doClear(); prime(32'h2000);
    walk(128, 6); walk(0, 4);
    endReport(mk(2'd2, 32'd128, 6, 10, 9, 4, 8, "R11"));

    // R5 / R3: alternating strides, tie goes to lowest index, no class
    doClear(); prime(32'h4000);
    for (int i = 0; i < 5; i++) begin walk(256, 1); walk(512, 1); end
    endReport(mk(2'd0, 32'd256, 5, 10, 9, 0, 0, "R5"));

    // R10: weak with one zero difference
    doClear(); prime(32'h8000);
    walk(320, 2);
    for (int i = 0; i < 4; i++) begin walk(0, 1); walk(320, 1); end
    endReport(mk(2'd3, 32'd320, 6, 10, 9, 4, 1, "R10"));

    // R6: near merge at 31, miss at 32, double match to lowest index
    doClear(); prime(32'h10000);
    walk(100, 1); walk(131, 1); walk(132, 1); walk(69, 1); walk(116, 1);
    endReport(mk(2'd1, 32'd100, 4, 5, 4, 0, 0, "R6"));

    // R7: LFU replacement with tie to lowest index
    doClear(); prime(32'h20000);
    walk(1000, 3); walk(2000, 1); walk(3000, 2); walk(4000, 1);
    walk(5000, 1); walk(2000, 1); walk(4000, 3);
    endReport(mk(2'd2, 32'd4000, 4, 12, 11, 0, 5, "R7"));

    // R4: only zero strides
    doClear(); prime(32'h30000);
    walk(0, 5);
    endReport(mk(2'd0, 32'd0, 0, 5, 4, 5, 4, "R4"));

    // R3: negative stride
    doClear(); prime(32'h40000);
    walk(-96, 4);
    endReport(mk(2'd1, 32'hFFFF_FFA0, 4, 4, 3, 0, 3, "R3"));

    // R12: end in the same cycle as an address excludes it, profiling goes on
    doClear(); prime(32'h50000);
    walk(64, 3);
    @(negedge clk);
    cur = cur + 32'd64;
    addrValid = 1'b1; addr = cur; endWindow = 1'b1;
    expQ.push_back(mk(2'd1, 32'd64, 3, 3, 2, 0, 2, "R12"));
    @(negedge clk);
    addrValid = 1'b0; endWindow = 1'b0;
    @(negedge clk);
    check("R12", "reportValid held", {31'd0, reportValid}, 32'd1);
    endReport(mk(2'd1, 32'd64, 4, 4, 3, 0, 3, "R12"));

    repeat (3) @(negedge clk);
    check("R12", "pending reports", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule